// File: doc/BRIEF.md
# Windowed Block Memory Copier

This block moves a contiguous window of words from a large source memory into a smaller destination memory. It moves one word per clock cycle and never assigns a whole array at once. Software or a neighbouring controller first fills the source through a plain write port. It then pulses `start` with a base offset. The block walks an index from zero to the last window slot. For each index it reads the source at base plus index and writes that word into the destination at the index itself. When the final word has landed, it pulses `done`.

Both memories are internal synchronous arrays with one element touched per port per cycle, so each one maps onto block RAM and not onto flip-flops. The source read has one cycle of latency. The write side therefore trails the read side by one cycle. Addresses that run past the end of the source wrap around to its start.

The sizes are set by parameters. The depth used at full scale is 131072 source words and 4095 destination words. The defaults are smaller so that a full copy stays quick to elaborate. The memory ports are plain, single-cycle ports with no back-pressure. A read of the destination returns its word on the clock edge after the address is presented.

Top module: `win_copier`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `busy` and `done` are both 0.
- R2: A `start` sampled high while `busy` is low makes `busy` read 1 after that clock edge. `busy` then stays high for exactly WIN_LEN+1 cycles.
- R3: `done` is high for exactly one cycle. That cycle is the first one in which `busy` reads 0 again, and every fall of `busy` comes with `done`.
- R4: After a copy with base B, destination word i holds source word (B+i) mod SRC_DEPTH, for every i from 0 to WIN_LEN-1.
- R5: The base offset is captured on the accepted `start`. Changing `base` while `busy` is high has no effect on the copied data.
- R6: A `start` pulse while `busy` is high is ignored. It neither restarts nor lengthens the copy, and the data still comes from the first base.
- R7: A window whose end passes source address SRC_DEPTH-1 continues at source address 0.
- R8: `dst_rdata` shows the destination word at `dst_raddr`, as sampled on the previous clock edge (one cycle of read latency).
- R9: A copy may start in the same cycle that `done` is high, and it then behaves as R2 to R4 describe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything acts on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Single-cycle request to begin a copy |
| base | input | SAW | Source offset of window slot 0 |
| busy | output | 1 | High while a copy is in flight |
| done | output | 1 | One-cycle pulse when the copy completes |
| src_we | input | 1 | Source write enable |
| src_waddr | input | SAW | Source write address |
| src_wdata | input | DW | Source write data (signed word, copied bit for bit) |
| dst_raddr | input | DAW | Destination read address |
| dst_rdata | output | DW | Destination read data, one cycle after the address |

## Verification
If the index counter holds a wrong value or stops at the wrong count, `busy` stays high for the wrong number of cycles. This is visible at the ports on the first copy, the cycle `done` should have fired. If the base register or the address adder is wrong, the destination contents diverge from the model on the first word read back. A wrap fault only shows in a window that straddles the source end. A skew in the one-cycle read alignment shifts every destination word by one slot, so the very first slot checked already disagrees.

// File: rtl/wc_pkg.sv
package wc_pkg;
  localparam int WC_SRC_DEPTH = 1024;
  localparam int WC_WIN_LEN   = 100;
  localparam int WC_DW        = 16;
endpackage

// File: rtl/wc_ram.sv
module wc_ram #(
  parameter int DW    = 16,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/wc_seq.sv
module wc_seq #(
  parameter int SRC_DEPTH = 1024,
  parameter int WIN_LEN   = 100,
  localparam int SAW      = $clog2(SRC_DEPTH),
  localparam int DAW      = $clog2(WIN_LEN)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [SAW-1:0] base,
  output logic           busy,
  output logic           done,
  output logic [SAW-1:0] src_raddr,
  output logic           dst_we,
  output logic [DAW-1:0] dst_waddr
);
  localparam logic [DAW-1:0] LAST = DAW'(WIN_LEN - 1);

  logic           reading;
  logic [DAW-1:0] rd_idx;
  logic [SAW-1:0] base_q;
  logic           wr_pend;
  logic [DAW-1:0] wr_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      reading <= 1'b0;
      rd_idx  <= '0;
      base_q  <= '0;
      wr_pend <= 1'b0;
      wr_idx  <= '0;
    end else begin
      done    <= 1'b0;
      wr_pend <= reading;
      wr_idx  <= rd_idx;
      if (start && !busy) begin
        busy    <= 1'b1;
        reading <= 1'b1;
        rd_idx  <= '0;
        base_q  <= base;
      end else if (reading) begin
        rd_idx <= rd_idx + 1'b1;
        if (rd_idx == LAST) reading <= 1'b0;
      end
      if (wr_pend && wr_idx == LAST) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  // Source address wraps by truncation to SAW bits.
  assign src_raddr = base_q + SAW'(rd_idx);
  assign dst_we    = wr_pend;
  assign dst_waddr = wr_idx;
endmodule

// File: rtl/win_copier.sv
module win_copier #(
  parameter int SRC_DEPTH = wc_pkg::WC_SRC_DEPTH,
  parameter int WIN_LEN   = wc_pkg::WC_WIN_LEN,
  parameter int DW        = wc_pkg::WC_DW,
  localparam int SAW      = $clog2(SRC_DEPTH),
  localparam int DAW      = $clog2(WIN_LEN)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [SAW-1:0] base,
  output logic           busy,
  output logic           done,
  input  logic           src_we,
  input  logic [SAW-1:0] src_waddr,
  input  logic [DW-1:0]  src_wdata,
  input  logic [DAW-1:0] dst_raddr,
  output logic [DW-1:0]  dst_rdata
);
  logic [SAW-1:0] src_raddr;
  logic [DW-1:0]  src_rdata;
  logic           dst_we;
  logic [DAW-1:0] dst_waddr;

  wc_seq #(.SRC_DEPTH(SRC_DEPTH), .WIN_LEN(WIN_LEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .base(base),
    .busy(busy), .done(done), .src_raddr(src_raddr),
    .dst_we(dst_we), .dst_waddr(dst_waddr)
  );

  wc_ram #(.DW(DW), .DEPTH(SRC_DEPTH)) u_src (
    .clk(clk), .we(src_we), .waddr(src_waddr), .wdata(src_wdata),
    .raddr(src_raddr), .rdata(src_rdata)
  );

  wc_ram #(.DW(DW), .DEPTH(WIN_LEN)) u_dst (
    .clk(clk), .we(dst_we), .waddr(dst_waddr), .wdata(src_rdata),
    .raddr(dst_raddr), .rdata(dst_rdata)
  );
endmodule

// File: rtl/wc_chk.sv
module wc_chk #(
  parameter int WIN_LEN = 100
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done
);
  int unsigned bcnt;

  always_ff @(posedge clk) begin
    if (!rst_n)    bcnt <= 0;
    else if (busy) bcnt <= bcnt + 1;
    else           bcnt <= 0;
  end

  p_busy_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_busy_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (bcnt == 32'(WIN_LEN + 1)));

  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_at_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_fall_has_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_rise_from_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

bind win_copier wc_chk #(.WIN_LEN(WIN_LEN)) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done)
);

// File: tb/test_win_copier.sv
module test_win_copier;
  localparam int SRC_DEPTH = wc_pkg::WC_SRC_DEPTH;
  localparam int WIN_LEN   = wc_pkg::WC_WIN_LEN;
  localparam int DW        = wc_pkg::WC_DW;
  localparam int SAW       = $clog2(SRC_DEPTH);
  localparam int DAW       = $clog2(WIN_LEN);
  localparam int NV        = 5;

  // Vector table: base offset, disturb flag (base change + stray start), expected busy cycles
  localparam int VBASE [NV] = '{0, 37, SRC_DEPTH - WIN_LEN, SRC_DEPTH - 10, 511};
  localparam bit VDIST [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam int VCYC  [NV] = '{WIN_LEN + 1, WIN_LEN + 1, WIN_LEN + 1, WIN_LEN + 1, WIN_LEN + 1};

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [SAW-1:0] base = '0;
  logic           busy, done;
  logic           src_we = 1'b0;
  logic [SAW-1:0] src_waddr = '0;
  logic [DW-1:0]  src_wdata = '0;
  logic [DAW-1:0] dst_raddr = '0;
  logic [DW-1:0]  dst_rdata;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  win_copier i_win_copier (
    .clk(clk), .rst_n(rst_n), .start(start), .base(base),
    .busy(busy), .done(done), .src_we(src_we), .src_waddr(src_waddr),
    .src_wdata(src_wdata), .dst_raddr(dst_raddr), .dst_rdata(dst_rdata)
  );

  function automatic logic [DW-1:0] srcval(int a);
    return DW'(a * 40503 + 4660);
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Returns busy cycle count; checks done pulse at busy fall.
  task automatic run_copy(int b, bit disturb, output int cyc, output int done_ok);
    @(negedge clk);
    start = 1'b1;
    base  = SAW'(b);
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    done_ok = 0;
    while (busy && cyc < 4 * WIN_LEN) begin
      cyc++;
      if (disturb && cyc == 5) begin
        base  = SAW'(b + 77);
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    done_ok = (done === 1'b1) ? 1 : 0;
    @(negedge clk);
    if (done !== 1'b0) done_ok = 0;
  endtask

  task automatic check_dst(string req, int b);
    int bad = 0;
    int first_i = -1;
    int first_a = 0;
    int first_e = 0;
    for (int i = 0; i < WIN_LEN; i++) begin
      dst_raddr = DAW'(i);
      @(negedge clk);
      if (dst_rdata !== srcval((b + i) % SRC_DEPTH)) begin
        if (first_i < 0) begin
          first_i = i;
          first_a = int'(dst_rdata);
          first_e = int'(srcval((b + i) % SRC_DEPTH));
        end
        bad++;
      end
    end
    tests++;
    if (bad != 0) begin
      fails++;
      $display("FAIL %s: base %0d slot %0d actual %0d expected %0d (%0d bad)",
               req, b, first_i, first_a, first_e, bad);
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int cyc, dok;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", int'(busy), 0);
    check("R1 done in reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", int'(busy), 0);
    check("R1 done after reset", int'(done), 0);

    for (int a = 0; a < SRC_DEPTH; a++) begin
      src_we = 1'b1;
      src_waddr = SAW'(a);
      src_wdata = srcval(a);
      @(negedge clk);
    end
    src_we = 1'b0;

    // Table walk: R2, R3, R4, R5/R6 (disturbed rows), R7 (wrapping rows), R8 via readback
    for (int v = 0; v < NV; v++) begin
      run_copy(VBASE[v], VDIST[v], cyc, dok);
      check("R2 busy length", cyc, VCYC[v]);
      check("R3 single done at fall", dok, 1);
      if (VDIST[v]) check_dst("R5 R6 data from first base", VBASE[v]);
      else if (VBASE[v] + WIN_LEN > SRC_DEPTH) check_dst("R7 wrapped window", VBASE[v]);
      else check_dst("R4 R8 window data", VBASE[v]);
    end

    // R8: latency exactly one cycle: address change not visible before the edge
    dst_raddr = DAW'(3);
    @(negedge clk);
    dst_raddr = DAW'(4);
    #1;
    check("R8 old word held before edge", int'(dst_rdata), int'(srcval((511 + 3) % SRC_DEPTH)));
    @(negedge clk);
    check("R8 new word after edge", int'(dst_rdata), int'(srcval((511 + 4) % SRC_DEPTH)));

    // R9: start again in the done cycle
    @(negedge clk);
    start = 1'b1;
    base  = SAW'(200);
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    check("R9 done before restart", int'(done), 1);
    start = 1'b1;
    base  = SAW'(SRC_DEPTH - 1);
    @(negedge clk);
    start = 1'b0;
    check("R9 busy after restart in done cycle", int'(busy), 1);
    cyc = 1;
    while (busy && cyc < 4 * WIN_LEN) begin
      @(negedge clk);
      if (busy) cyc++;
    end
    check("R9 restart busy length", cyc, WIN_LEN + 1);
    @(negedge clk);
    check_dst("R9 R7 restarted copy data", SRC_DEPTH - 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule